// File: doc/BRIEF.md
# Chained Multiply-Add Vector Convoy

This block executes the scaled-vector update `a*X[i] + Y[i]` as one convoy of two pipelined functional units. A multiply-by-scalar unit feeds an add unit, and the two are chained. The adder takes element i as soon as the multiplier produces it, so it never waits for the whole product vector to finish. The operands X[i] and Y[i] arrive as a stream, one element per clock at most. The block sends back one result per element, in element order, after a fixed pipeline delay.

A vector starts with its first valid element and closes with the element that carries the last flag. The scalar is taken together with the first element. The Y operand runs through a delay line that matches the multiplier depth, so it reaches the adder in the same cycle as its product. A chime counter measures the convoy from its first element to its last result and reports that length once.

Top module: `vchain_convoy`

## Requirements
- R1: After a cycle with `rst` high, `out_valid` and `count_done` are 0 and `cycle_count` is 0.
- R2: Each result is the unsigned value `a*X[i] + Y[i]`, at full width `2*DATA_W+1` bits, with no truncation. At the defaults, 65535*65535+65535 is reported exactly.
- R3: A result is presented exactly `MUL_LAT + ADD_LAT` cycles after the cycle in which its element was presented with `in_valid` high. This is 13 cycles at the defaults. Results come out one per element, in element order, even when elements arrive on every clock.
- R4: A cycle with `in_valid` low produces no result. Idle gaps in the input stream reappear unchanged in the output stream.
- R5: `scalar_in` is sampled in the cycle of a vector's first element. Changes to it are ignored until that vector's `count_done` pulse.
- R6: At completion, `cycle_count` equals the cycle of the last result minus the cycle of the first element. For n contiguous elements this is n + 13 - 1.
- R7: `out_last` is 1 only on the result of the element that was presented with `in_last`. `count_done` is a one-cycle pulse in the cycle right after that result.
- R8: Each Y operand reaches the add unit in the same cycle as the product of its own element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An element is presented this cycle |
| scalar_in | input | DATA_W | Scalar multiplier, taken with the first element of a vector |
| vec_x | input | DATA_W | Element X[i] |
| vec_y | input | DATA_W | Element Y[i] |
| in_last | input | 1 | Marks the final element of the vector |
| out_valid | output | 1 | A result is presented this cycle |
| out_data | output | 2*DATA_W+1 | Result a*X[i]+Y[i] |
| out_last | output | 1 | Result belongs to the final element |
| cycle_count | output | CNT_W | Convoy length from first element to last result |
| count_done | output | 1 | One-cycle pulse: cycle_count has been updated |

## Verification
While a vector is longer than the pipeline depth, new elements enter and earlier results leave in the same cycle. The test provokes this with long contiguous vectors and judges it by the exact due cycle and value of every result. In the same way, the scalar latch and a change of `scalar_in` can fall in the same convoy. The test alters `scalar_in` on every element after the first and expects results computed with the first value only. The closing of the chime counter is timed against the last result, in the cycle that follows it.

// File: rtl/vchain_pkg.sv
package vchain_pkg;

  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_MUL_LAT = 7;
  localparam int unsigned DEF_ADD_LAT = 6;
  localparam int unsigned DEF_CNT_W   = 16;

  // Cycles from presenting an element to seeing its result.
  function automatic int unsigned convoy_latency(input int unsigned mul_lat,
                                                 input int unsigned add_lat);
    return mul_lat + add_lat;
  endfunction

  typedef enum logic {
    CHIME_IDLE = 1'b0,
    CHIME_RUN  = 1'b1
  } chime_state_e;

endpackage

// File: rtl/vchain_delay.sv
// Valid/data shift register of configurable depth. The data path has no
// reset so it can map onto shift-register or RAM-based delay primitives.
module vchain_delay #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_valid,
  input  logic [WIDTH-1:0] d_data,
  output logic             q_valid,
  output logic [WIDTH-1:0] q_data
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q_valid = d_valid;
      assign q_data  = d_data;
    end else begin : g_shift
      logic [DEPTH-1:0] vld_sr;
      logic [WIDTH-1:0] dat_sr [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_sr <= '0;
        end else begin
          vld_sr[0] <= d_valid;
          for (int k = 1; k < DEPTH; k++) begin
            vld_sr[k] <= vld_sr[k-1];
          end
        end
      end

      always_ff @(posedge clk) begin
        dat_sr[0] <= d_data;
        for (int k = 1; k < DEPTH; k++) begin
          dat_sr[k] <= dat_sr[k-1];
        end
      end

      assign q_valid = vld_sr[DEPTH-1];
      assign q_data  = dat_sr[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/vchain_mul_unit.sv
// Multiply-by-scalar functional unit: product formed in the first stage,
// then carried through LATENCY-1 further stages with its last flag.
module vchain_mul_unit #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned LATENCY = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic                op_last,
  input  logic [DATA_W-1:0]   op_scalar,
  input  logic [DATA_W-1:0]   op_elem,
  output logic                prod_valid,
  output logic                prod_last,
  output logic [2*DATA_W-1:0] prod_data
);

  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned TAIL   = LATENCY - 1;

  logic              s1_valid;
  logic              s1_last;
  logic [PROD_W-1:0] s1_prod;
  logic [PROD_W:0]   tail_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= op_valid;
    end
  end

  always_ff @(posedge clk) begin
    s1_last <= op_last & op_valid;
    s1_prod <= {{DATA_W{1'b0}}, op_scalar} * {{DATA_W{1'b0}}, op_elem};
  end

  vchain_delay #(
    .DEPTH (TAIL),
    .WIDTH (PROD_W + 1)
  ) i_tail (
    .clk     (clk),
    .rst     (rst),
    .d_valid (s1_valid),
    .d_data  ({s1_last, s1_prod}),
    .q_valid (prod_valid),
    .q_data  (tail_data)
  );

  assign prod_last = tail_data[PROD_W];
  assign prod_data = tail_data[PROD_W-1:0];

endmodule

// File: rtl/vchain_add_unit.sv
// Add functional unit chained to the multiplier: sums each product with its
// aligned Y operand in the first stage, then LATENCY-1 further stages.
module vchain_add_unit #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned LATENCY = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prod_valid,
  input  logic                prod_last,
  input  logic [2*DATA_W-1:0] prod_data,
  input  logic                y_valid,
  input  logic [DATA_W-1:0]   y_data,
  output logic                sum_valid,
  output logic                sum_last,
  output logic [2*DATA_W:0]   sum_data
);

  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned RES_W  = PROD_W + 1;
  localparam int unsigned TAIL   = LATENCY - 1;

  logic             s1_valid;
  logic             s1_last;
  logic [RES_W-1:0] s1_sum;
  logic [RES_W:0]   tail_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= prod_valid & y_valid;
    end
  end

  always_ff @(posedge clk) begin
    s1_last <= prod_last & prod_valid;
    s1_sum  <= {1'b0, prod_data} + {{(RES_W-DATA_W){1'b0}}, y_data};
  end

  vchain_delay #(
    .DEPTH (TAIL),
    .WIDTH (RES_W + 1)
  ) i_tail (
    .clk     (clk),
    .rst     (rst),
    .d_valid (s1_valid),
    .d_data  ({s1_last, s1_sum}),
    .q_valid (sum_valid),
    .q_data  (tail_data)
  );

  assign sum_last = tail_data[RES_W];
  assign sum_data = tail_data[RES_W-1:0];

endmodule

// File: rtl/vchain_chime_counter.sv
// Measures a convoy: opens on the first element, closes on the last result.
module vchain_chime_counter
  import vchain_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             res_valid,
  input  logic             res_last,
  output logic             busy,
  output logic [CNT_W-1:0] cycle_count,
  output logic             count_done
);

  chime_state_e     state;
  logic [CNT_W-1:0] running;
  logic             closing;

  assign closing = (state == CHIME_RUN) && res_valid && res_last;
  assign busy    = (state == CHIME_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= CHIME_IDLE;
      running     <= '0;
      cycle_count <= '0;
      count_done  <= 1'b0;
    end else begin
      count_done <= 1'b0;
      case (state)
        CHIME_IDLE: begin
          if (in_valid) begin
            state   <= CHIME_RUN;
            running <= CNT_W'(1);
          end
        end
        CHIME_RUN: begin
          if (closing) begin
            state       <= CHIME_IDLE;
            cycle_count <= running;
            count_done  <= 1'b1;
          end else begin
            running <= running + CNT_W'(1);
          end
        end
        default: state <= CHIME_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vchain_convoy.sv
// Chained convoy: a*X[i] + Y[i] through a multiply unit feeding an add unit.
module vchain_convoy
  import vchain_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned MUL_LAT = DEF_MUL_LAT,
  parameter int unsigned ADD_LAT = DEF_ADD_LAT,
  parameter int unsigned CNT_W   = DEF_CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   scalar_in,
  input  logic [DATA_W-1:0]   vec_x,
  input  logic [DATA_W-1:0]   vec_y,
  input  logic                in_last,
  output logic                out_valid,
  output logic [2*DATA_W:0]   out_data,
  output logic                out_last,
  output logic [CNT_W-1:0]    cycle_count,
  output logic                count_done
);

  localparam int unsigned PROD_W = 2 * DATA_W;

  logic              busy;
  logic [DATA_W-1:0] a_hold;
  logic [DATA_W-1:0] a_eff;

  logic              mul_valid;
  logic              mul_last;
  logic [PROD_W-1:0] mul_prod;

  logic              y_valid;
  logic [DATA_W-1:0] y_dly;

  // Scalar is captured with the first element and held for the convoy.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_hold <= '0;
    end else if (!busy && in_valid) begin
      a_hold <= scalar_in;
    end
  end

  assign a_eff = busy ? a_hold : scalar_in;

  vchain_mul_unit #(
    .DATA_W  (DATA_W),
    .LATENCY (MUL_LAT)
  ) i_mul (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (in_valid),
    .op_last    (in_last),
    .op_scalar  (a_eff),
    .op_elem    (vec_x),
    .prod_valid (mul_valid),
    .prod_last  (mul_last),
    .prod_data  (mul_prod)
  );

  // Y operand waits as long as the multiplier takes.
  vchain_delay #(
    .DEPTH (MUL_LAT),
    .WIDTH (DATA_W)
  ) i_ydly (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_data  (vec_y),
    .q_valid (y_valid),
    .q_data  (y_dly)
  );

  vchain_add_unit #(
    .DATA_W  (DATA_W),
    .LATENCY (ADD_LAT)
  ) i_add (
    .clk        (clk),
    .rst        (rst),
    .prod_valid (mul_valid),
    .prod_last  (mul_last),
    .prod_data  (mul_prod),
    .y_valid    (y_valid),
    .y_data     (y_dly),
    .sum_valid  (out_valid),
    .sum_last   (out_last),
    .sum_data   (out_data)
  );

  vchain_chime_counter #(
    .CNT_W (CNT_W)
  ) i_chime (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .res_valid   (out_valid),
    .res_last    (out_last),
    .busy        (busy),
    .cycle_count (cycle_count),
    .count_done  (count_done)
  );

endmodule

// File: rtl/vchain_convoy_chk.sv
module vchain_convoy_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TOTAL_LAT = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              mul_valid,
  input logic              y_valid,
  input logic              busy,
  input logic [DATA_W-1:0] a_hold,
  input logic              out_valid,
  input logic              out_last,
  input logic [CNT_W-1:0]  cycle_count,
  input logic              count_done
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !count_done));

  assert_no_orphan_result_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  assert_scalar_held_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(a_hold));

  assert_min_chime_R6: assert property (@(posedge clk) disable iff (rst)
    count_done |-> (cycle_count >= CNT_W'(TOTAL_LAT)));

  assert_done_follows_last_R7: assert property (@(posedge clk) disable iff (rst)
    count_done |-> $past(out_valid && out_last));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    count_done |=> !count_done);

  assert_operand_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    mul_valid == y_valid);

endmodule

bind vchain_convoy vchain_convoy_chk #(
  .DATA_W    (DATA_W),
  .CNT_W     (CNT_W),
  .TOTAL_LAT (MUL_LAT + ADD_LAT)
) i_vchain_convoy_chk (
  .clk         (clk),
  .rst         (rst),
  .mul_valid   (mul_valid),
  .y_valid     (y_valid),
  .busy        (busy),
  .a_hold      (a_hold),
  .out_valid   (out_valid),
  .out_last    (out_last),
  .cycle_count (cycle_count),
  .count_done  (count_done)
);

// File: tb/test_vchain_convoy.sv
module test_vchain_convoy;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int RES_W      = 2 * DATA_W + 1;
  localparam int CNT_W      = 16;
  localparam int LAT        = 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] scalar_in = '0;
  logic [DATA_W-1:0] vec_x = '0;
  logic [DATA_W-1:0] vec_y = '0;
  logic              in_last = 1'b0;
  logic              out_valid;
  logic [RES_W-1:0]  out_data;
  logic              out_last;
  logic [CNT_W-1:0]  cycle_count;
  logic              count_done;

  vchain_convoy #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) i_vchain_convoy (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .scalar_in   (scalar_in),
    .vec_x       (vec_x),
    .vec_y       (vec_y),
    .in_last     (in_last),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .cycle_count (cycle_count),
    .count_done  (count_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int               due_q[$];
  logic [RES_W-1:0] val_q[$];
  bit               last_q[$];
  int               first_cyc;
  int               last_res_cyc;
  int               vec_len;
  bit               contiguous;
  bit               done_seen;
  bit               prev_done;
  bit               finished = 0;

  function automatic logic [RES_W-1:0] model(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] x,
                                             input logic [DATA_W-1:0] y);
    longint unsigned r;
    r = longint'(a) * longint'(x) + longint'(y);
    return r[RES_W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_test();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (due_q.size() == 0) begin
          check(0, "R4 result without element", 1, 0);
        end else begin
          int d;
          logic [RES_W-1:0] v;
          bit l;
          d = due_q.pop_front();
          v = val_q.pop_front();
          l = last_q.pop_front();
          check(cyc == d, "R3 result latency", cyc, d);
          check(out_data == v, "R2 R8 result value", out_data, v);
          check(out_last == l, "R7 last flag", out_last, l);
          if (l) last_res_cyc = cyc;
        end
      end else if (due_q.size() > 0 && due_q[0] == cyc) begin
        check(0, "R3 R4 missing result", 0, 1);
        void'(due_q.pop_front());
        void'(val_q.pop_front());
        void'(last_q.pop_front());
      end
      if (count_done) begin
        check(cycle_count == CNT_W'(last_res_cyc - first_cyc), "R6 chime count",
              cycle_count, last_res_cyc - first_cyc);
        if (contiguous)
          check(cycle_count == CNT_W'(vec_len + LAT - 1), "R6 n+13-1", cycle_count, vec_len + LAT - 1);
        check(cyc == last_res_cyc + 1, "R7 done timing", cyc, last_res_cyc + 1);
        check(!prev_done, "R7 done width", prev_done, 0);
        done_seen = 1;
      end
      prev_done = count_done;
    end
  end

  // Drive one vector. gap_pct: chance of an idle cycle; chg: alter scalar after first element.
  task automatic run_vector(input int n, input logic [DATA_W-1:0] a,
                            input int gap_pct, input bit chg, input bit maxval);
    int i = 0;
    done_seen  = 0;
    vec_len    = n;
    contiguous = (gap_pct == 0);
    while (i < n) begin
      @(negedge clk);
      if (i > 0 && gap_pct > 0 && ($urandom % 100) < gap_pct) begin
        in_valid  = 1'b0;
        vec_x     = DATA_W'($urandom);
        in_last   = 1'b1;
        scalar_in = chg ? DATA_W'($urandom) : a;
      end else begin
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        x = maxval ? '1 : DATA_W'($urandom);
        y = maxval ? '1 : DATA_W'($urandom);
        in_valid  = 1'b1;
        vec_x     = x;
        vec_y     = y;
        in_last   = (i == n - 1);
        scalar_in = (i == 0 || !chg) ? a : DATA_W'($urandom); // R5: later values ignored
        if (i == 0) first_cyc = cyc;
        due_q.push_back(cyc + LAT);
        val_q.push_back(model(a, x, y));
        last_q.push_back(i == n - 1);
        i++;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_last   = 1'b0;
    scalar_in = DATA_W'($urandom);
    while (!done_seen) @(negedge clk);
    // Idle after completion: no stray result (R4).
    repeat (3) begin
      @(negedge clk);
      check(!out_valid, "R4 idle output", out_valid, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", cyc, 0);
    finish_test();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    @(negedge clk);
    check(!out_valid, "R1 out_valid reset", out_valid, 0);
    check(!count_done, "R1 done reset", count_done, 0);
    check(cycle_count == '0, "R1 count reset", cycle_count, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !count_done, "R1 quiet after reset", out_valid, 0);

    run_vector(1, 16'd3, 0, 0, 0);          // single element: count 13
    run_vector(64, 16'hFFFF, 0, 0, 1);      // full-scale operands, long chain
    run_vector(20, 16'd7, 30, 0, 0);        // idle gaps in the stream (R4)
    run_vector(12, 16'd11, 0, 1, 0);        // scalar changes mid-vector (R5)
    run_vector(2, 16'd0, 0, 0, 0);          // zero scalar
    for (int v = 0; v < 12; v++) begin
      run_vector(1 + int'($urandom % 40), DATA_W'($urandom),
                 (v % 3 == 0) ? 25 : 0, v[0], 0);
    end
    check(due_q.size() == 0, "R3 all results delivered", due_q.size(), 0);
    finish_test();
  end

endmodule